// File: doc/BRIEF.md
# Multi-Channel DMA Control Register and Interrupt Block

This block holds the programming state for a set of independent DMA transfer engines and gathers their completion events into one interrupt line. A host on a simple 32-bit memory-mapped bus programs each channel through a small bank of registers: a buffer base address, a line length, a line count and a control word. A separate array holds one stride value per channel. A few global registers are shared by all channels. One halts channels, one holds pending completions, one masks them and one enables looping. The engines are outside the block. Each sees its configuration on parallel outputs, a one-cycle start pulse, a one-cycle halt pulse and a loop-enable level. Each returns a one-cycle done pulse.

Setting up a channel ends with a write to its base address register, and that write launches the transfer. Completion pulses set sticky pending bits, and software clears them by writing ones. The combined interrupt is raised when any pending channel is also unmasked. The block also reports the highest-numbered channel that is pending and unmasked, so a handler can serve channels from the top down without scanning.

Top module: `dmac_csr_hub`

## Requirements
- R1: Channel n's bank starts at byte offset n*0x10. Offset +0x0 is the base address, +0x4 the line length and +0x8 the line count, each 32 bits read/write. Offset +0xC is the control word, which keeps bits [5:0] only: bits [3:0] hold the channel number, bit 4 selects burst mode and bit 5 selects direction. Bits [31:6] of the control word read as zero. The stored values appear on the matching cfg_* outputs.
- R2: A write to channel n's base address register drives eng_start with only bit n set, for exactly the one cycle after the write. cfg_base already shows the new value in that cycle. Writes to any other register do not pulse eng_start.
- R3: Channel n's stride register is a 32-bit read/write register at byte offset 0x100 + 4*n, shown on cfg_stride[n].
- R4: Writing 0x140 drives eng_halt with the written bit pattern for exactly the one cycle after the write. Bits written as 0 produce no halt. Reading 0x140 returns zero.
- R5: A done pulse on eng_done[n] sets pending bit n, and the bit stays set until software clears it.
- R6: The pending register at 0x144 reads back the pending bits. Writing 1 to bit n clears it, and writing 0 leaves it unchanged. If a done pulse and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R7: The mask register at 0x148 is read/write with one bit per channel. irq is high in a cycle exactly when, in the previous cycle, some channel was both pending and unmasked.
- R8: irq_chan gives the highest channel index that was pending and unmasked in the previous cycle, and it is 0 when irq is low.
- R9: The loop register at 0x150 is 32 bits read/write. eng_loop[n] is high only when both bit n and bit n+16 are set.
- R10: Reads of any other offset return zero. Writes to any other offset change no register and produce no pulse. This covers 0x14C, 0x154 and above, and stride slots past the last channel.
- R11: After reset every register, pending bit and output is zero.
- R12: A read request returns its data on bus_rdata in the following cycle. bus_rdata is zero in any cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after bus_rd |
| eng_done | input | NUM_CH | Per-channel completion pulses |
| eng_start | output | NUM_CH | Per-channel start pulses |
| eng_halt | output | NUM_CH | Per-channel halt pulses |
| eng_loop | output | NUM_CH | Per-channel loop enable |
| cfg_base | output | NUM_CH x DATA_W | Base address per channel |
| cfg_line | output | NUM_CH x DATA_W | Line length per channel |
| cfg_count | output | NUM_CH x DATA_W | Line count per channel |
| cfg_ctrl | output | NUM_CH x 6 | Control word per channel |
| cfg_stride | output | NUM_CH x DATA_W | Stride per channel |
| irq | output | 1 | Combined interrupt |
| irq_chan | output | log2(NUM_CH) | Highest pending unmasked channel |

## Verification
Some properties are checked on every cycle. Start and halt pulses are at most one-hot for starts, and each follows a bus write. A done pulse always leaves its pending bit set, even when a clear lands in the same cycle. irq_chan always names a channel that was live in the previous cycle, and it is zero when idle. Read data stays quiet outside read responses. Other behaviour can only be shown by the bench's scenarios. These are the address map and its read-back values, the six-bit truncation of the control word, the highest-index choice among several live channels, the need for both loop bits, and the silence of the unmapped offsets.

// File: rtl/dmac_csr_pkg.sv
package dmac_csr_pkg;
  // Byte offsets of the shared register space
  localparam int OFS_STRIDE = 32'h100;
  localparam int OFS_HALT   = 32'h140;
  localparam int OFS_PEND   = 32'h144;
  localparam int OFS_MASK   = 32'h148;
  localparam int OFS_LOOP   = 32'h150;
  localparam int BANK_BYTES = 16;
  localparam int CTRL_W     = 6;

  typedef enum logic [1:0] {
    SLOT_BASE  = 2'd0,
    SLOT_LINE  = 2'd1,
    SLOT_COUNT = 2'd2,
    SLOT_CTRL  = 2'd3
  } bank_slot_e;
endpackage

// File: rtl/dmac_chan_bank.sv
module dmac_chan_bank
  import dmac_csr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_bank,
  input  logic              wr_stride,
  input  logic [1:0]        slot,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] base,
  output logic [DATA_W-1:0] line,
  output logic [DATA_W-1:0] count,
  output logic [CTRL_W-1:0] ctrl,
  output logic [DATA_W-1:0] stride,
  output logic              start
);
  bank_slot_e slot_e;
  assign slot_e = bank_slot_e'(slot);

  always_ff @(posedge clk) begin
    if (rst) begin
      base   <= '0;
      line   <= '0;
      count  <= '0;
      ctrl   <= '0;
      stride <= '0;
      start  <= 1'b0;
    end else begin
      start <= wr_bank && (slot_e == SLOT_BASE);
      if (wr_bank) begin
        case (slot_e)
          SLOT_BASE:  base  <= wdata;
          SLOT_LINE:  line  <= wdata;
          SLOT_COUNT: count <= wdata;
          default:    ctrl  <= wdata[CTRL_W-1:0];
        endcase
      end
      if (wr_stride) stride <= wdata;
    end
  end
endmodule

// File: rtl/dmac_irq_ctrl.sv
module dmac_irq_ctrl #(
  parameter int NUM_CH = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] done,
  input  logic              clr_we,
  input  logic              mask_we,
  input  logic [NUM_CH-1:0] wdata,
  output logic [NUM_CH-1:0] pend,
  output logic [NUM_CH-1:0] mask,
  output logic              irq,
  output logic [CH_W-1:0]   irq_chan
);
  logic [NUM_CH-1:0] live;
  logic [CH_W-1:0]   top_idx;

  assign live = pend & mask;

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (live[i]) top_idx = CH_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= '0;
      mask     <= '0;
      irq      <= 1'b0;
      irq_chan <= '0;
    end else begin
      // a completion in the same cycle as a clear keeps the bit set
      if (clr_we) pend <= (pend & ~wdata) | done;
      else        pend <= pend | done;
      if (mask_we) mask <= wdata;
      irq      <= |live;
      irq_chan <= top_idx;
    end
  end
endmodule

// File: rtl/dmac_csr_hub.sv
module dmac_csr_hub
  import dmac_csr_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  input  logic [NUM_CH-1:0]              eng_done,
  output logic [NUM_CH-1:0]              eng_start,
  output logic [NUM_CH-1:0]              eng_halt,
  output logic [NUM_CH-1:0]              eng_loop,
  output logic [NUM_CH-1:0][DATA_W-1:0]  cfg_base,
  output logic [NUM_CH-1:0][DATA_W-1:0]  cfg_line,
  output logic [NUM_CH-1:0][DATA_W-1:0]  cfg_count,
  output logic [NUM_CH-1:0][CTRL_W-1:0]  cfg_ctrl,
  output logic [NUM_CH-1:0][DATA_W-1:0]  cfg_stride,
  output logic                           irq,
  output logic [CH_W-1:0]                irq_chan
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int LOOP_HI = DATA_W / 2;
  localparam logic [WORD_W-1:0] W_BANK_END   = WORD_W'(NUM_CH * BANK_BYTES / 4);
  localparam logic [WORD_W-1:0] W_STRIDE     = WORD_W'(OFS_STRIDE / 4);
  localparam logic [WORD_W-1:0] W_STRIDE_END = WORD_W'(OFS_STRIDE / 4 + NUM_CH);
  localparam logic [WORD_W-1:0] W_HALT       = WORD_W'(OFS_HALT / 4);
  localparam logic [WORD_W-1:0] W_PEND       = WORD_W'(OFS_PEND / 4);
  localparam logic [WORD_W-1:0] W_MASK       = WORD_W'(OFS_MASK / 4);
  localparam logic [WORD_W-1:0] W_LOOP       = WORD_W'(OFS_LOOP / 4);

  logic [WORD_W-1:0] word;
  logic              hit_bank, hit_stride, hit_halt, hit_pend, hit_mask, hit_loop;
  logic [CH_W-1:0]   bank_ch, stride_ch;
  logic [1:0]        slot;
  logic [NUM_CH-1:0] irq_pend, irq_mask;
  logic [DATA_W-1:0] loop_q, rd_mux;

  assign word       = bus_addr[ADDR_W-1:2];
  assign hit_bank   = word < W_BANK_END;
  assign bank_ch    = CH_W'(word >> 2);
  assign slot       = word[1:0];
  assign hit_stride = (word >= W_STRIDE) && (word < W_STRIDE_END);
  assign stride_ch  = CH_W'(word - W_STRIDE);
  assign hit_halt   = word == W_HALT;
  assign hit_pend   = word == W_PEND;
  assign hit_mask   = word == W_MASK;
  assign hit_loop   = word == W_LOOP;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dmac_chan_bank #(.DATA_W(DATA_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .wr_bank   (bus_wr && hit_bank && (bank_ch == CH_W'(g))),
      .wr_stride (bus_wr && hit_stride && (stride_ch == CH_W'(g))),
      .slot      (slot),
      .wdata     (bus_wdata),
      .base      (cfg_base[g]),
      .line      (cfg_line[g]),
      .count     (cfg_count[g]),
      .ctrl      (cfg_ctrl[g]),
      .stride    (cfg_stride[g]),
      .start     (eng_start[g])
    );
    assign eng_loop[g] = loop_q[g] & loop_q[g + LOOP_HI];
  end

  dmac_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .done     (eng_done),
    .clr_we   (bus_wr && hit_pend),
    .mask_we  (bus_wr && hit_mask),
    .wdata    (bus_wdata[NUM_CH-1:0]),
    .pend     (irq_pend),
    .mask     (irq_mask),
    .irq      (irq),
    .irq_chan (irq_chan)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_bank) begin
      case (bank_slot_e'(slot))
        SLOT_BASE:  rd_mux = cfg_base[bank_ch];
        SLOT_LINE:  rd_mux = cfg_line[bank_ch];
        SLOT_COUNT: rd_mux = cfg_count[bank_ch];
        default:    rd_mux = DATA_W'(cfg_ctrl[bank_ch]);
      endcase
    end else if (hit_stride) begin
      rd_mux = cfg_stride[stride_ch];
    end else if (hit_pend) begin
      rd_mux = DATA_W'(irq_pend);
    end else if (hit_mask) begin
      rd_mux = DATA_W'(irq_mask);
    end else if (hit_loop) begin
      rd_mux = loop_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_halt  <= '0;
      loop_q    <= '0;
      bus_rdata <= '0;
    end else begin
      eng_halt  <= (bus_wr && hit_halt) ? bus_wdata[NUM_CH-1:0] : '0;
      if (bus_wr && hit_loop) loop_q <= bus_wdata;
      bus_rdata <= bus_rd ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/dmac_csr_hub_chk.sv
module dmac_csr_hub_chk #(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 32,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_CH-1:0] eng_done,
  input logic [NUM_CH-1:0] eng_start,
  input logic [NUM_CH-1:0] eng_halt,
  input logic [NUM_CH-1:0] irq_pend,
  input logic [NUM_CH-1:0] irq_mask,
  input logic              irq,
  input logic [CH_W-1:0]   irq_chan
);
  logic [NUM_CH-1:0] live_q;
  always_ff @(posedge clk) live_q <= irq_pend & irq_mask;

  // R2
  start_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(eng_start));
  // R2
  start_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_start != '0) |-> $past(bus_wr));
  // R4
  halt_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_halt != '0) |-> $past(bus_wr));
  // R6
  done_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_done != '0) |=> ((irq_pend & $past(eng_done)) == $past(eng_done)));
  // R8
  irq_chan_live_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> live_q[irq_chan]);
  // R8
  idle_chan_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !irq |-> (irq_chan == '0));
  // R12
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

bind dmac_csr_hub dmac_csr_hub_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .eng_done  (eng_done),
  .eng_start (eng_start),
  .eng_halt  (eng_halt),
  .irq_pend  (irq_pend),
  .irq_mask  (irq_mask),
  .irq       (irq),
  .irq_chan  (irq_chan)
);

// File: tb/sim_dmac_csr_hub.sv
`timescale 1ns/1ps
module sim_dmac_csr_hub;
  localparam int NCH = 16;
  localparam int AW  = 9;
  localparam int DW  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NCH-1:0] eng_done = '0;
  logic [NCH-1:0] eng_start, eng_halt, eng_loop;
  logic [NCH-1:0][DW-1:0] cfg_base, cfg_line, cfg_count, cfg_stride;
  logic [NCH-1:0][5:0] cfg_ctrl;
  logic irq;
  logic [3:0] irq_chan;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dmac_csr_hub u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_done(eng_done),
    .eng_start(eng_start), .eng_halt(eng_halt), .eng_loop(eng_loop),
    .cfg_base(cfg_base), .cfg_line(cfg_line), .cfg_count(cfg_count),
    .cfg_ctrl(cfg_ctrl), .cfg_stride(cfg_stride), .irq(irq), .irq_chan(irq_chan)
  );

  function automatic logic [31:0] pat(int ch, int r);
    return 32'(32'h9E3779B9 * (ch * 4 + r + 1)) ^ 32'h5A5A0000;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    check("R11 irq", 32'(irq), 0);
    check("R11 start", 32'(eng_start), 0);
    check("R11 loop", 32'(eng_loop), 0);
    rd(9'h144, d); check("R11 pend", d, 0);
    rd(9'h150, d); check("R11 loopreg", d, 0);
    for (int ch = 0; ch < NCH; ch++) begin
      for (int r = 0; r < 4; r++) begin
        rd(9'(ch * 16 + r * 4), d); check("R11 bank", d, 0);
      end
    end

    // R1 R2: program every bank, base address written last
    for (int ch = 0; ch < NCH; ch++) begin
      for (int r = 3; r >= 0; r--) begin
        wr(9'(ch * 16 + r * 4), pat(ch, r));
        if (r == 0) begin
          check("R2 start pulse", 32'(eng_start), 32'(1) << ch);
          check("R2 base visible", cfg_base[ch], pat(ch, 0));
          @(negedge clk);
          check("R2 pulse width", 32'(eng_start), 0);
        end else begin
          check("R2 no start", 32'(eng_start), 0);
        end
      end
      check("R1 line out", cfg_line[ch], pat(ch, 1));
      check("R1 count out", cfg_count[ch], pat(ch, 2));
      check("R1 ctrl out", 32'(cfg_ctrl[ch]), pat(ch, 3) & 32'h3F);
    end
    // R3: strides
    for (int ch = 0; ch < NCH; ch++) begin
      wr(9'(9'h100 + ch * 4), ~pat(ch, 0));
      check("R3 stride out", cfg_stride[ch], ~pat(ch, 0));
      check("R3 no start", 32'(eng_start), 0);
    end
    // R1 R3 R12: read back everything
    for (int ch = 0; ch < NCH; ch++) begin
      for (int r = 0; r < 4; r++) begin
        rd(9'(ch * 16 + r * 4), d);
        check("R1 readback", d, (r == 3) ? (pat(ch, r) & 32'h3F) : pat(ch, r));
      end
      rd(9'(9'h100 + ch * 4), d); check("R3 readback", d, ~pat(ch, 0));
    end
    @(negedge clk);
    check("R12 quiet rdata", bus_rdata, 0);

    // R4: halt pulses
    for (int ch = 0; ch < NCH; ch++) begin
      wr(9'h140, 32'(1) << ch);
      check("R4 halt pulse", 32'(eng_halt), 32'(1) << ch);
      @(negedge clk);
      check("R4 halt width", 32'(eng_halt), 0);
    end
    wr(9'h140, 32'h8001);
    check("R4 halt multi", 32'(eng_halt), 32'h8001);
    rd(9'h140, d); check("R4 halt reads zero", d, 0);

    // R5 R6 R7 R8: one channel at a time
    wr(9'h148, 32'hFFFF);
    rd(9'h148, d); check("R7 mask readback", d, 32'hFFFF);
    for (int ch = 0; ch < NCH; ch++) begin
      @(negedge clk); eng_done = NCH'(1) << ch;
      @(negedge clk); eng_done = '0;
      @(negedge clk);
      check("R7 irq raised", 32'(irq), 1);
      check("R8 chan", 32'(irq_chan), 32'(ch));
      rd(9'h144, d); check("R5 pend sticky", d, 32'(1) << ch);
      wr(9'h144, 32'h0); rd(9'h144, d); check("R6 zero write", d, 32'(1) << ch);
      wr(9'h144, 32'(1) << ch); rd(9'h144, d); check("R6 cleared", d, 0);
      check("R7 irq dropped", 32'(irq), 0);
      check("R8 idle chan", 32'(irq_chan), 0);
    end
    // R8: priority among several
    @(negedge clk); eng_done = 16'h0208;
    @(negedge clk); eng_done = '0;
    @(negedge clk);
    check("R8 highest", 32'(irq_chan), 9);
    wr(9'h148, 32'hFDFF);
    @(negedge clk);
    check("R8 masked top", 32'(irq_chan), 3);
    wr(9'h148, 32'h0);
    @(negedge clk);
    check("R7 all masked", 32'(irq), 0);
    rd(9'h144, d); check("R7 mask keeps pend", d, 32'h0208);
    // R6: set wins over clear
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 9'h144; bus_wdata = 32'h0228; eng_done = 16'h0020;
    @(negedge clk);
    bus_wr = 1'b0; eng_done = '0;
    rd(9'h144, d); check("R6 set wins", d, 32'h0020);
    wr(9'h144, 32'hFFFF);

    // R9: loop enable needs both halves
    for (int ch = 0; ch < NCH; ch++) begin
      wr(9'h150, 32'(1) << ch);
      @(negedge clk); check("R9 low only", 32'(eng_loop), 0);
      wr(9'h150, 32'(1) << (ch + 16));
      @(negedge clk); check("R9 high only", 32'(eng_loop), 0);
      wr(9'h150, (32'(1) << ch) | (32'(1) << (ch + 16)));
      @(negedge clk); check("R9 both", 32'(eng_loop), 32'(1) << ch);
    end
    wr(9'h150, 32'h00F0_0F0F);
    rd(9'h150, d); check("R9 readback", d, 32'h00F0_0F0F);
    check("R9 mixed", 32'(eng_loop), 32'h0000_000F & 32'h0000_00F0 | 32'h0);

    // R10: unmapped offsets
    wr(9'h148, 32'h00A5);
    begin
      logic [AW-1:0] holes[4] = '{9'h14C, 9'h154, 9'h180, 9'h1FC};
      foreach (holes[i]) begin
        wr(holes[i], 32'hFFFF_FFFF);
        check("R10 no start", 32'(eng_start), 0);
        check("R10 no halt", 32'(eng_halt), 0);
        rd(holes[i], d); check("R10 read zero", d, 0);
      end
    end
    rd(9'h148, d); check("R10 mask intact", d, 32'h00A5);
    rd(9'h150, d); check("R10 loop intact", d, 32'h00F0_0F0F);
    rd(9'h144, d); check("R10 pend intact", d, 0);
    rd(9'h13C, d); check("R10 last stride intact", d, ~pat(15, 0));

    finish_run();
  end
endmodule